// File: doc/BRIEF.md
# Debug-Board Interrupt Expander

This block collects interrupt requests from a handful of peripheral sources on a debug board. It presents one summary interrupt to the host processor. Each source pin first passes through a two-flop synchronizer. A per-source polarity parameter then turns it into an asserted level, and that level sets a sticky bit in the status register. A mask register decides which latched bits may reach the summary output. The summary output is active low and level-sensitive. It stays low for as long as any unmasked status bit remains set.

Software reaches the block over a small synchronous register bus. The bus has a 3-bit word address, a write strobe, 16-bit write data and registered 16-bit read data. Status is cleared through a separate clear register. Software writes ones to the bits it wants cleared, then writes zero to release them. Three constant identification words and a version word let software confirm that the board is fitted before it touches anything else. The register map in word offsets is: 0 status (read-only), 1 mask, 2 clear (reads 0), 3, 4 and 5 the identification words, 6 version. Offset 7 reads 0.

Top module: `dbg_irq_hub`

## Requirements
- R1: When reset is released, status reads 0x0000, mask reads 0xFFFF, the clear register reads 0x0000 and `irq_n` is high.
- R2: Offsets 3, 4 and 5 read 0xAAAA, 0x5555 and 0xCAFE. Offset 6 reads the `CODE_REV` parameter. Writes to offsets 3 to 6 are ignored.
- R3: An asserted source level sets its status bit on the third rising edge after the pin changes. The bit stays set after the source goes inactive, until it is cleared.
- R4: A source whose bit in `SRC_ACT_LOW` is 1 is asserted when its pin is low. The default is 5'b00001, so source 0 is active low and sources 1 to 4 are active high.
- R5: `irq_n` is registered. It is low exactly when status AND NOT mask (the low NUM_SRC bits) was non-zero on the previous edge. A mask bit of 1 disables its source. The first effect of a pin change appears on `irq_n` on the fourth rising edge.
- R6: A 1 written into bit i of the clear register clears status bit i. While that bit stays 1, status bit i stays 0 even if the source is still asserted. Once 0 is written back, a still-asserted source sets the bit again.
- R7: Status bits at and above NUM_SRC always read 0. A bus write to the status offset has no effect.
- R8: Read data is registered: `bus_rdata` shows the register that was addressed at the previous rising edge. The clear offset and offset 7 always read 0x0000.
- R9: Masking does not stop latching. A masked source still sets its status bit, and that bit raises `irq_n` as soon as it is unmasked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_in | input | NUM_SRC | Raw interrupt source pins, asynchronous |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the previous cycle's address |
| irq_n | output | 1 | Active-low, level-sensitive summary interrupt |

## Verification
The bench builds the block with its defaults: five sources, source 0 active low and the rest active high, and a version word of 0x0103. With these values one source exercises the inverted polarity path while the others exercise the direct path. The unused status bits 5 to 15 can be checked as zeros. The mask and clear registers can be driven with patterns that mix enabled and disabled sources, which brings the sticky-latch, held-clear and re-arm orderings within reach.

// File: rtl/dbg_irq_pkg.sv
`timescale 1ns/1ps
package dbg_irq_pkg;
  localparam int REG_W = 16;
  localparam int ADR_W = 3;

  typedef enum logic [ADR_W-1:0] {
    SEL_STATUS = 3'd0,
    SEL_MASK   = 3'd1,
    SEL_CLEAR  = 3'd2,
    SEL_ID0    = 3'd3,
    SEL_ID1    = 3'd4,
    SEL_ID2    = 3'd5,
    SEL_REV    = 3'd6
  } reg_sel_e;

  localparam logic [REG_W-1:0] ID_WORD0 = 16'hAAAA;
  localparam logic [REG_W-1:0] ID_WORD1 = 16'h5555;
  localparam logic [REG_W-1:0] ID_WORD2 = 16'hCAFE;
endpackage

// File: rtl/dbg_irq_sync.sv
`timescale 1ns/1ps
module dbg_irq_sync #(
  parameter int               WIDTH  = 5,
  parameter int               STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= IDLE;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dbg_irq_status.sv
`timescale 1ns/1ps
module dbg_irq_status #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_hit,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] status
);
  logic [NUM_SRC-1:0] status_q, status_d;
  logic               status_en;

  always_comb begin
    status_d  = (status_q | src_hit) & ~clr;
    status_en = (status_d != status_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  assign status = status_q;

  // sticky bits only fall under a clear
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((($past(status_q) & ~$past(clr)) & ~status_q) == '0));

  // an asserted, uncleared source is latched on the next edge
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((($past(src_hit) & ~$past(clr)) & ~status_q) == '0));

  // a held clear keeps its bits at zero
  p_clear_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((status_q & $past(clr)) == '0));
endmodule

// File: rtl/dbg_irq_regs.sv
`timescale 1ns/1ps
module dbg_irq_regs
  import dbg_irq_pkg::*;
#(
  parameter int               NUM_SRC  = 5,
  parameter logic [REG_W-1:0] CODE_REV = 16'h0103
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADR_W-1:0]   bus_addr,
  input  logic               bus_we,
  input  logic [REG_W-1:0]   bus_wdata,
  input  logic [NUM_SRC-1:0] status,
  output logic [REG_W-1:0]   mask,
  output logic [NUM_SRC-1:0] clr,
  output logic [REG_W-1:0]   bus_rdata
);
  logic [REG_W-1:0]   mask_q, mask_d;
  logic               mask_en;
  logic [NUM_SRC-1:0] clr_q, clr_d;
  logic               clr_en;
  logic [REG_W-1:0]   rdata_q, rdata_d;
  logic [REG_W-1:0]   status_word;

  always_comb begin
    mask_en = bus_we && (bus_addr == SEL_MASK);
    mask_d  = bus_wdata;
    clr_en  = bus_we && (bus_addr == SEL_CLEAR);
    clr_d   = bus_wdata[NUM_SRC-1:0];
  end

  always_comb begin
    status_word = '0;
    status_word[NUM_SRC-1:0] = status;
  end

  always_comb begin
    case (bus_addr)
      SEL_STATUS: rdata_d = status_word;
      SEL_MASK:   rdata_d = mask_q;
      SEL_ID0:    rdata_d = ID_WORD0;
      SEL_ID1:    rdata_d = ID_WORD1;
      SEL_ID2:    rdata_d = ID_WORD2;
      SEL_REV:    rdata_d = CODE_REV;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      clr_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (clr_en)  clr_q  <= clr_d;
      rdata_q <= rdata_d;
    end
  end

  assign mask      = mask_q;
  assign clr       = clr_q;
  assign bus_rdata = rdata_q;

  p_id_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ($past(bus_addr) != SEL_ID2 || bus_rdata == 16'hCAFE));

  p_clear_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ($past(bus_addr) != SEL_CLEAR || bus_rdata == '0));

  p_mask_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == SEL_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/dbg_irq_hub.sv
`timescale 1ns/1ps
module dbg_irq_hub
  import dbg_irq_pkg::*;
#(
  parameter int                 NUM_SRC     = 5,
  parameter logic [NUM_SRC-1:0] SRC_ACT_LOW = 5'b00001,
  parameter logic [REG_W-1:0]   CODE_REV    = 16'h0103
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [ADR_W-1:0]   bus_addr,
  input  logic               bus_we,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               irq_n
);
  logic [1:0]         rst_pipe_q;
  logic               rst_n_int;
  logic [NUM_SRC-1:0] src_sync, src_hit;
  logic [NUM_SRC-1:0] status_w, clr_w;
  logic [REG_W-1:0]   mask_w;
  logic [NUM_SRC-1:0] pending;
  logic               irq_n_q, irq_n_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  dbg_irq_sync #(.WIDTH(NUM_SRC), .STAGES(2), .IDLE(SRC_ACT_LOW)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     (src_in),
    .q     (src_sync)
  );

  assign src_hit = src_sync ^ SRC_ACT_LOW;

  dbg_irq_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .src_hit (src_hit),
    .clr     (clr_w),
    .status  (status_w)
  );

  dbg_irq_regs #(.NUM_SRC(NUM_SRC), .CODE_REV(CODE_REV)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .status    (status_w),
    .mask      (mask_w),
    .clr       (clr_w),
    .bus_rdata (bus_rdata)
  );

  always_comb begin
    pending = status_w & ~mask_w[NUM_SRC-1:0];
    irq_n_d = ~(|pending);
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) irq_n_q <= 1'b1;
    else            irq_n_q <= irq_n_d;
  end

  assign irq_n = irq_n_q;

  p_summary_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    1 |=> (irq_n == ~(|($past(status_w) & ~$past(mask_w[NUM_SRC-1:0])))));

  p_quiet_when_masked_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (&mask_w[NUM_SRC-1:0]) |=> irq_n);
endmodule

// File: tb/dbg_irq_hub_test.sv
`timescale 1ns/1ps
module dbg_irq_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  src_pins = 5'b00001;
  logic [2:0]  bus_addr = 3'd0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic        irq_n;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  int          stamp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbg_irq_hub uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_pins),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  // monitor: pops one expected word per completed read
  always @(negedge clk) begin : monitor
    logic [15:0] e;
    string t;
    if (stamp_q.size() > 0 && cyc == stamp_q[0] + 1) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      void'(stamp_q.pop_front());
      n_vec++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string t);
    @(posedge clk); #1;
    bus_addr = a;
    bus_we   = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(t);
    stamp_q.push_back(cyc);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk); #1;
    bus_we    = 1'b0;
    bus_addr  = 3'd7;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_vec++;
    if (irq_n !== e) begin
      n_bad++;
      $display("FAIL %s: irq_n=%b expected %b", t, irq_n, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    idle(3); #1;
    rst_n = 1'b1;
    idle(5); #1;
    chk_irq(1'b1, "R1 irq idle");
    rd(3'd0, 16'h0000, "R1 status reset");
    rd(3'd1, 16'hFFFF, "R1 mask reset");
    rd(3'd2, 16'h0000, "R1 clear reset");

    rd(3'd3, 16'hAAAA, "R2 id0");
    rd(3'd4, 16'h5555, "R2 id1");
    rd(3'd5, 16'hCAFE, "R2 id2");
    rd(3'd6, 16'h0103, "R2 version");
    rd(3'd7, 16'h0000, "R8 offset7");

    // masked source still latches, sticky after release
    @(posedge clk); #1 src_pins[2] = 1'b1;
    idle(2); #1 src_pins[2] = 1'b0;
    idle(5); #1;
    rd(3'd0, 16'h0004, "R3 sticky R9 masked latch");
    idle(1); #1;
    chk_irq(1'b1, "R5 masked source");
    wr(3'd2, 16'h0004);
    wr(3'd2, 16'h0000);
    idle(2);
    rd(3'd0, 16'h0000, "R6 clear pulse");
    wr(3'd1, 16'hFFE0);
    rd(3'd1, 16'hFFE0, "R5 mask readback");
    idle(2); #1;
    chk_irq(1'b1, "R5 no pending");

    // exact latency from pin to irq_n
    @(posedge clk); #1 src_pins[1] = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk_irq(1'b1, "R3 latency third edge");
    @(posedge clk);
    #1 chk_irq(1'b0, "R5 fourth edge asserted");
    rd(3'd0, 16'h0002, "R3 status set");

    // held clear against an active source
    wr(3'd2, 16'h0002);
    idle(2);
    rd(3'd0, 16'h0000, "R6 held clear");
    idle(2);
    rd(3'd0, 16'h0000, "R6 still held");
    #1 chk_irq(1'b1, "R6 irq released");
    wr(3'd2, 16'h0000);
    idle(2);
    rd(3'd0, 16'h0002, "R6 re-arm");

    // active-low source 0
    @(posedge clk); #1 src_pins[0] = 1'b0;
    idle(4);
    rd(3'd0, 16'h0003, "R4 active-low source");

    // status and id writes ignored
    wr(3'd0, 16'h0000);
    rd(3'd0, 16'h0003, "R7 status write ignored");
    wr(3'd3, 16'h1234);
    rd(3'd3, 16'hAAAA, "R2 id write ignored");
    wr(3'd6, 16'hFFFF);
    rd(3'd6, 16'h0103, "R2 version write ignored");

    // all sources asserted
    @(posedge clk); #1 src_pins = 5'b11110;
    idle(4);
    rd(3'd0, 16'h001F, "R7 upper bits zero");
    wr(3'd2, 16'hFFFF);
    idle(2);
    rd(3'd0, 16'h0000, "R6 clear all held");
    rd(3'd2, 16'h0000, "R8 clear reads zero");
    idle(1); #1;
    chk_irq(1'b1, "R6 irq with all cleared");
    wr(3'd2, 16'h0000);
    idle(3);
    rd(3'd0, 16'h001F, "R6 all re-armed");

    // mask behaviour
    wr(3'd1, 16'hFFFF);
    idle(2); #1;
    chk_irq(1'b1, "R5 all masked");
    wr(3'd1, 16'hA5A5);
    rd(3'd1, 16'hA5A5, "R5 mask pattern");
    idle(2); #1;
    chk_irq(1'b0, "R9 unmasked latched bits");

    idle(4);
    finish_run();
  end
endmodule